// File: doc/BRIEF.md
# Quadrant Write-Protect Command Controller

This block sits on a two-wire serial bus (I2C signalling) as a slave front end for a memory whose array is divided into four quadrants. It watches the clock and data lines. After each START condition it shifts in the first byte and checks whether that byte is a command to protect one quadrant or to clear all protection. Such commands are honoured only while a high-voltage qualifier input is asserted. That input stands for a raised voltage on an address pin, here presented as a synchronous digital level.

A command byte has the form `0110 c c c 0`: the high nibble is fixed, bits 3..1 hold a command code, and bit 0 (the read/write bit) must be 0. An accepted command is acknowledged in the ninth clock. It takes effect on the STOP condition that follows, provided the qualifier stayed high for the whole sequence. A set command adds exactly one quadrant to the 4-bit protection register. Only the clear command removes protection, and it removes all of it at once.

For ordinary memory writes the block also gives a combinational write-inhibit flag. The flag is the protection bit of the quadrant selected by the two most significant bits of the 9-bit write address. At reset the register loads from a preload input, which models the retained state, and its value is always visible on a status output.

Top module: `qwp_ctrl`

## Requirements
- R1: While reset is held low, the protection register loads from `preload`; `prot_status` shows that value after reset is released.
- R2: With the qualifier high, byte `0110ccc0` sets one protection bit: code 001 → bit 0, 100 → bit 1, 101 → bit 2, 000 → bit 3 (`prot_status[i]` is quadrant i).
- R3: Code 011 in that byte clears all four protection bits in one command.
- R4: A set command only ORs its one bit into the register. Setting an already protected quadrant leaves the register unchanged. Two quadrants need two set commands.
- R5: A valid command byte sent while the qualifier is high is acknowledged: `sda_oe` is 1 (SDA pulled low) during the high phase of the ninth SCL clock.
- R6: Any other byte is not acknowledged and changes nothing. This covers codes 010, 110 and 111, a read/write bit of 1, a different high nibble, and the qualifier being low at START.
- R7: If the qualifier is low in any cycle between START and STOP, the command is abandoned and the register is unchanged, even if the qualifier returns before STOP.
- R8: The register changes only on the STOP that ends an acknowledged command. Before that STOP, `prot_status` keeps its old value.
- R9: Bytes that follow an acknowledged command byte are never acknowledged (`sda_oe` stays 0 in their ninth clock), and they do not cancel the pending command.
- R10: `write_inhibit` equals `prot_status[wr_addr[8:7]]`; address bits 8:7 = 00 select quadrant 0 and 11 select quadrant 3.
- R11: A repeated START before STOP discards any pending command and decodes the next byte afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level (asynchronous) |
| sda_in | input | 1 | Serial data line level (asynchronous) |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| hv_present | input | 1 | High-voltage qualifier, synchronous level |
| preload | input | 4 | Protection value loaded during reset |
| wr_addr | input | 9 | Byte address of an ordinary memory write |
| write_inhibit | output | 1 | Write to `wr_addr` is blocked |
| prot_status | output | 4 | Current protection register |

## Verification
The hardest case to reach from the ports is a qualifier that drops and returns within one command. The byte must still look valid, and the drop must fall in a window that only the bus phase defines: during the address bits, after the acknowledge, or between trailing data bytes and STOP. The bench drives a cycle-level bus model. Each random transaction picks one of these drop points, or none, together with a random code, read/write bit, prefix and optional data byte. It then compares the acknowledge and the register after STOP against a bench model.

// File: rtl/qwp_pkg.sv
// Package: shared constants, state type and command decode for the
// quadrant write-protect controller. Assumes four quadrants.
package qwp_pkg;

    localparam int NQ = 4;
    localparam logic [3:0] CMD_PREFIX = 4'b0110;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ACK,
        S_DATA,
        S_DNACK,
        S_SKIP
    } qwp_state_t;

    typedef struct packed {
        logic          valid;
        logic          clr;
        logic [NQ-1:0] mask;
    } qwp_cmd_t;

    // Decode an address byte into a protect/clear command.
    function automatic qwp_cmd_t decode_cmd(input logic [7:0] b);
        qwp_cmd_t c;
        c = '0;
        if (b[7:4] == CMD_PREFIX && !b[0]) begin
            unique case (b[3:1])
                3'b001:  begin c.valid = 1'b1; c.mask = 4'b0001; end
                3'b100:  begin c.valid = 1'b1; c.mask = 4'b0010; end
                3'b101:  begin c.valid = 1'b1; c.mask = 4'b0100; end
                3'b000:  begin c.valid = 1'b1; c.mask = 4'b1000; end
                3'b011:  begin c.valid = 1'b1; c.clr  = 1'b1;    end
                default: c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/qwp_bus_sync.sv
// Module: synchronises SCL/SDA into the clk domain and reports line
// events (SCL edges, START, STOP). Assumes the bus idles high and the
// bus phases last several clk cycles.
module qwp_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Shift both lines through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Hold the previous synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/qwp_cmd_fsm.sv
// Module: bus slave sequencer. Captures the address byte after START,
// decides ACK/NACK, NACKs any data bytes, tracks the high-voltage
// qualifier over the whole sequence and issues a one-cycle commit on STOP.
// Assumes events from qwp_bus_sync.
module qwp_cmd_fsm
    import qwp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_s,
    input  logic          hv_present,
    output logic          sda_oe,
    output logic          commit_set,
    output logic          commit_clr,
    output logic [NQ-1:0] commit_mask
);
    localparam int BITS = 8;
    localparam int CW   = $clog2(BITS + 1);

    qwp_state_t state;
    logic [7:0] shreg;
    logic [CW-1:0] bitcnt;
    logic       acked;
    logic       hv_ok;
    qwp_cmd_t   cmd_q;
    qwp_cmd_t   cmd_now;

    assign cmd_now = decode_cmd(shreg);

    // Sequence the bus transaction and produce the commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            shreg      <= '0;
            bitcnt     <= '0;
            acked      <= 1'b0;
            hv_ok      <= 1'b0;
            cmd_q      <= '0;
            sda_oe     <= 1'b0;
            commit_set <= 1'b0;
            commit_clr <= 1'b0;
        end else begin
            commit_set <= 1'b0;
            commit_clr <= 1'b0;
            if (!hv_present) hv_ok <= 1'b0;
            if (stop_det) begin
                if (state != S_IDLE && acked && hv_ok && hv_present) begin
                    commit_set <= ~cmd_q.clr;
                    commit_clr <= cmd_q.clr;
                end
                state  <= S_IDLE;
                acked  <= 1'b0;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state  <= S_ADDR;
                bitcnt <= '0;
                acked  <= 1'b0;
                sda_oe <= 1'b0;
                hv_ok  <= hv_present;
            end else begin
                unique case (state)
                    S_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CW'(BITS)) begin
                            state <= S_ACK;
                            cmd_q <= cmd_now;
                            if (cmd_now.valid && hv_ok && hv_present) begin
                                sda_oe <= 1'b1;
                                acked  <= 1'b1;
                            end
                        end
                    end
                    S_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= acked ? S_DATA : S_SKIP;
                        end
                    end
                    S_DATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CW'(BITS)) begin
                            state <= S_DNACK;
                        end
                    end
                    S_DNACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            state  <= S_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign commit_mask = cmd_q.mask;

    // A commit follows a STOP seen on the previous cycle.
    assert_commit_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_set || commit_clr) |-> $past(stop_det));

    // A commit requires the qualifier in the cycle of the STOP.
    assert_commit_hv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_set || commit_clr) |-> $past(hv_present));

    // Set and clear never fire together.
    assert_single_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_set, commit_clr}));

    // The acknowledge driver never starts on a STOP or START.
    assert_ack_not_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det || start_det) |=> !$rose(sda_oe));

endmodule

// File: rtl/qwp_prot_reg.sv
// Module: 4-bit protection register with preload on reset, sticky set,
// clear-all, and the per-address write-inhibit lookup. Assumes the
// quadrant is given by the top two address bits.
module qwp_prot_reg
    import qwp_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NQ-1:0]     preload,
    input  logic              commit_set,
    input  logic              commit_clr,
    input  logic [NQ-1:0]     commit_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              write_inhibit,
    output logic [NQ-1:0]     prot_q
);
    localparam int QW = $clog2(NQ);

    logic [QW-1:0] quad;

    // Load, set one quadrant, or clear all protection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= preload;
        end else if (commit_clr) begin
            prot_q <= '0;
        end else if (commit_set) begin
            prot_q <= prot_q | commit_mask;
        end
    end

    assign quad          = wr_addr[ADDR_W-1 -: QW];
    assign write_inhibit = prot_q[quad];

    // Without a commit the register holds.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_set && !commit_clr) |=> $stable(prot_q));

    // Clear empties the register.
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_clr |=> (prot_q == '0));

    // Set keeps every bit already protected and adds at most one.
    assert_set_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_set |=> (((prot_q & $past(prot_q)) == $past(prot_q))
                        && ($countones(prot_q) <= $countones($past(prot_q)) + 1)));

endmodule

// File: rtl/qwp_ctrl.sv
// Module: top of the quadrant write-protect command controller. Wires the
// bus synchroniser, command sequencer and protection register.
// Assumes SDA is open-drain: sda_oe = 1 pulls the line low.
module qwp_ctrl
    import qwp_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              hv_present,
    input  logic [NQ-1:0]     preload,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              write_inhibit,
    output logic [NQ-1:0]     prot_status
);
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          sda_s;
    logic          commit_set;
    logic          commit_clr;
    logic [NQ-1:0] commit_mask;

    qwp_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s)
    );

    qwp_cmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .sda_s       (sda_s),
        .hv_present  (hv_present),
        .sda_oe      (sda_oe),
        .commit_set  (commit_set),
        .commit_clr  (commit_clr),
        .commit_mask (commit_mask)
    );

    qwp_prot_reg #(.ADDR_W(ADDR_W)) u_prot (
        .clk           (clk),
        .rst_n         (rst_n),
        .preload       (preload),
        .commit_set    (commit_set),
        .commit_clr    (commit_clr),
        .commit_mask   (commit_mask),
        .wr_addr       (wr_addr),
        .write_inhibit (write_inhibit),
        .prot_q        (prot_status)
    );

endmodule

// File: tb/qwp_ctrl_tb.sv
module qwp_ctrl_tb;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       tb_sda = 1'b1;
    logic       hv = 1'b1;
    logic [3:0] preload = 4'b0101;
    logic [8:0] wr_addr = '0;
    logic       sda_oe;
    logic       write_inhibit;
    logic [3:0] prot_status;
    logic       sda_line;

    int vectors = 0;
    int fails   = 0;
    logic [3:0] model;

    assign sda_line = tb_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    qwp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .hv_present(hv), .preload(preload),
        .wr_addr(wr_addr), .write_inhibit(write_inhibit),
        .prot_status(prot_status)
    );

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic exp_valid(input logic [7:0] b);
        return b[7:4] == 4'b0110 && !b[0] &&
               (b[3:1] inside {3'b001, 3'b100, 3'b101, 3'b000, 3'b011});
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] p, input logic [7:0] b);
        case (b[3:1])
            3'b001:  return p | 4'b0001;
            3'b100:  return p | 4'b0010;
            3'b101:  return p | 4'b0100;
            3'b000:  return p | 4'b1000;
            3'b011:  return 4'b0000;
            default: return p;
        endcase
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tb_sda = 1'b1; wt(H); scl = 1'b1; wt(H);
        tb_sda = 1'b0; wt(H); scl = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        tb_sda = 1'b0; wt(H); scl = 1'b1; wt(H);
        tb_sda = 1'b1; wt(H);
    endtask

    // Send one byte MSB first; drop_bit >= 0 lowers hv before that bit.
    task automatic send_byte(input logic [7:0] b, input int drop_bit, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            if (drop_bit == 7 - i) hv = 1'b0;
            tb_sda = b[i]; wt(H);
            scl = 1'b1; wt(H);
            scl = 1'b0; wt(H);
        end
        tb_sda = 1'b1; wt(H);
        scl = 1'b1; wt(H / 2);
        ack = ~sda_line;
        wt(H - H / 2);
        scl = 1'b0; wt(H);
    endtask

    // Whole command with a chosen qualifier disturbance.
    // mode 0 none, 1 absent, 2 drop in address, 3 drop after ack, 4 drop before stop.
    task automatic run_cmd(input logic [7:0] b, input int mode, input logic with_data, input string req);
        logic ack, dack, exp_ack;
        hv = (mode != 1);
        bus_start();
        send_byte(b, (mode == 2) ? 3 : -1, ack);
        exp_ack = exp_valid(b) && (mode == 0 || mode == 3 || mode == 4);
        chk(ack, exp_ack, {req, " ack"});
        if (mode == 3) begin hv = 1'b0; wt(2); hv = 1'b1; end
        if (with_data) begin
            send_byte($urandom, -1, dack);
            chk(dack, 1'b0, "R9 data nack");
        end
        if (mode == 4) begin hv = 1'b0; wt(2); hv = 1'b1; end
        chk(prot_status, model, "R8 before stop");
        bus_stop();
        wt(6);
        if (exp_ack && mode == 0) model = exp_next(model, b);
        hv = 1'b1;
        chk(prot_status, model, {req, " after stop"});
    endtask

    initial begin
        logic a;
        wt(4);
        rst_n = 1'b1;
        wt(2);
        model = 4'b0101;
        chk(prot_status, 4'b0101, "R1 preload");
        chk(sda_oe, 1'b0, "R1 sda idle");

        run_cmd(8'b0110_0110, 0, 1'b0, "R3 clear");
        run_cmd(8'b0110_0010, 0, 1'b0, "R2 set q0");
        run_cmd(8'b0110_1000, 0, 1'b0, "R2 set q1");
        run_cmd(8'b0110_1010, 0, 1'b0, "R2 set q2");
        run_cmd(8'b0110_0110, 0, 1'b0, "R3 clear");
        run_cmd(8'b0110_0000, 0, 1'b0, "R2 set q3");
        run_cmd(8'b0110_0000, 0, 1'b0, "R4 repeat set");
        run_cmd(8'b0110_0010, 0, 1'b1, "R9 set with data");
        run_cmd(8'b0110_0100, 0, 1'b0, "R6 code 010");
        run_cmd(8'b0110_1100, 0, 1'b0, "R6 code 110");
        run_cmd(8'b0110_1110, 0, 1'b0, "R6 code 111");
        run_cmd(8'b0110_0111, 0, 1'b0, "R6 rw one");
        run_cmd(8'b1010_0110, 0, 1'b0, "R6 prefix");
        run_cmd(8'b0110_0110, 1, 1'b0, "R6 hv absent");
        run_cmd(8'b0110_0110, 2, 1'b0, "R7 drop in addr");
        run_cmd(8'b0110_0110, 3, 1'b0, "R7 drop after ack");
        run_cmd(8'b0110_0110, 4, 1'b1, "R7 drop before stop");

        // R10 inhibit per quadrant
        for (int q = 0; q < 4; q++) begin
            wr_addr = {q[1:0], 7'($urandom)};
            wt(1);
            chk(write_inhibit, model[q], "R10 inhibit");
        end

        // R11 repeated start discards pending clear, then valid set applies
        hv = 1'b1;
        bus_start();
        send_byte(8'b0110_0110, -1, a);
        chk(a, 1'b1, "R11 first ack");
        bus_start();
        send_byte(8'b0110_1110, -1, a);
        chk(a, 1'b0, "R11 second nack");
        bus_stop(); wt(6);
        chk(prot_status, model, "R11 discarded");
        bus_start();
        send_byte(8'b0110_0110, -1, a);
        bus_start();
        send_byte(8'b0110_1010, -1, a);
        chk(a, 1'b1, "R11 restart ack");
        bus_stop(); wt(6);
        model = exp_next(model, 8'b0110_1010);
        chk(prot_status, model, "R11 restart applied");

        // Constrained random mix
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 110; n++) begin
            logic [7:0] b;
            int mode;
            b = $urandom;
            if ($urandom % 4 != 0) b[7:4] = 4'b0110;
            if ($urandom % 8 != 0) b[0] = 1'b0;
            mode = $urandom % 8;
            if (mode > 4) mode = 0;
            run_cmd(b, mode, ($urandom % 3) == 0, "R2/R3/R6/R7 random");
            wr_addr = $urandom;
            wt(1);
            chk(write_inhibit, model[wr_addr[8:7]], "R10 random inhibit");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule